// File: doc/BRIEF.md
# Hysteretic PLL Lock Status Detector

This block watches a phase-locked loop and reports two loss-of-lock flags. For frequency lock, it counts edges of the loop's feedback clock during gate windows. Each window lasts a programmed number of reference-clock cycles. The window counts are summed over a power-of-two group of windows, and the total is compared with the programmed nominal count scaled by the group size. For phase lock, the magnitude of each phase-error sample from an external phase detector is compared with a pair of thresholds. Each flag has one threshold for declaring lock and a larger one for declaring loss of lock. While the error lies between the two, the flag keeps its value.

An alternate-oscillator mode hands the frequency measurement to a second clock, which is then timed against the reference clock (a crystal in that use). The phase monitor keeps watching the main loop. Software reads a four-bit status word. Each status pin can show a chosen flag or a combination of the flags. The feedback and alternate clocks may be fully asynchronous to the reference. Their edge counts cross into the reference domain as Gray code through a two-flop synchronizer.

Top module: `pll_lock_monitor`

## Requirements
- R1: When a group of 2^A gate windows completes, the frequency error E is |sum of the window counts − nominal_cnt·2^A|, where A = avg_log2 (0 to 7). If E is below the scaled lock threshold, the frequency flag (status bit 0, 1 = unlocked) clears on that group's final reference edge.
- R2: If, at a group's completion, E is above the scaled unlock threshold, the frequency flag sets.
- R3: If, at a group's completion, E is neither below the scaled lock threshold nor above the scaled unlock threshold, the frequency flag keeps its value. This holds whether the flag was set or clear, and whether the count is above or below nominal.
- R4: Frequency thresholds are programmed in counts per window. They are scaled by 2^A before comparison, so a fixed relative error gives the same decision at any averaging factor.
- R5: The frequency flag changes only at group completion. A group lasts gate_len·2^A reference cycles, so a longer gate or more averaging delays the first decision after a restart.
- R6: Each frequency threshold is first clamped to (2^ERR_W − 1) >> A and then scaled. E saturates at 2^ERR_W − 1.
- R7: On a reference edge with ph_valid high, let M be the magnitude of the signed two's-complement ph_err. The phase flag (status bit 1) clears if M < ph_lock_thr, sets if M > ph_unlock_thr, and otherwise holds. With ph_valid low, the phase flag does not change.
- R8: With alt_mode high, the frequency path counts alt_clk instead of fb_clk. The phase flag keeps following the phase-error samples.
- R9: Reset, a restart pulse, or any change of alt_mode sets both flags on the next reference edge and restarts gate, group and accumulation from zero.
- R10: The status word is {alt mode active (bit 3), both locked (bit 2), phase unlocked (bit 1), frequency unlocked (bit 0)}. Bit 3 follows alt_mode one reference edge later.
- R11: For pin p, the select value pin_sel[2p+1:2p] chooses what the pin shows: 0 shows the frequency flag, 1 the phase flag, 2 the OR of the two flags, and 3 the both-locked indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all status logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_clk | input | 1 | Main loop feedback clock being measured |
| alt_clk | input | 1 | Alternate oscillator clock |
| alt_mode | input | 1 | 1 = frequency path measures alt_clk |
| restart | input | 1 | Pulse: restart measurement and flag both unlocked |
| gate_len | input | GATE_W | Gate window length in reference cycles |
| nominal_cnt | input | NOM_W | Expected feedback count per window |
| avg_log2 | input | AVG_W | log2 of windows averaged per decision |
| freq_lock_thr | input | ERR_W | Frequency lock threshold, counts per window |
| freq_unlock_thr | input | ERR_W | Frequency unlock threshold, counts per window |
| ph_valid | input | 1 | Phase-error sample strobe |
| ph_err | input | PH_W | Signed phase-error sample |
| ph_lock_thr | input | PH_W | Phase lock magnitude threshold |
| ph_unlock_thr | input | PH_W | Phase unlock magnitude threshold |
| pin_sel | input | 2*NPINS | Two-bit source select per status pin |
| status | output | 4 | Status word |
| pin_out | output | NPINS | Status pin drives |

## Verification
The feedback clock is driven at steady counts above, at and below nominal. This separates clearing, setting and the two hold cases inside the hysteresis band, starting from either flag state, so a one-sided error or a lost hold band is caught. The averaging factor is swept while a constant relative error is applied, which exposes wrong threshold scaling. A deep-averaging case with oversized thresholds gives a different decision only if the clamp is present. The phase comparison is swept over every sample value for several threshold pairs and both starting states, with idle cycles that expose an ignored strobe. Mode switches with conflicting feedback and alternate frequencies show which clock is being counted.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

  // Absolute difference of two unsigned quantities.
  function automatic logic [31:0] plm_abs_diff(logic [31:0] a, logic [31:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // Clip a value to the largest number that fits in w bits.
  function automatic logic [31:0] plm_saturate(logic [31:0] v, logic [31:0] w);
    logic [31:0] top;
    top = (32'd1 << w) - 32'd1;
    return (v > top) ? top : v;
  endfunction

  // Per-window threshold -> group threshold: clamp so the scaled value fits, then scale.
  function automatic logic [31:0] plm_scale_thr(logic [31:0] thr, logic [31:0] avg,
                                                logic [31:0] w);
    logic [31:0] lim;
    logic [31:0] t;
    lim = ((32'd1 << w) - 32'd1) >> avg;
    t   = (thr > lim) ? lim : thr;
    return t << avg;
  endfunction

  // Hysteretic decision: 1 = unlocked.
  function automatic logic plm_hyst(logic cur, logic [31:0] err, logic [31:0] lock_t,
                                    logic [31:0] unlock_t);
    if (err < lock_t)   return 1'b0;
    if (err > unlock_t) return 1'b1;
    return cur;
  endfunction

  function automatic logic [31:0] plm_bin2gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] plm_gray2bin(logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  typedef enum logic [1:0] {
    PIN_FREQ   = 2'd0,
    PIN_PHASE  = 2'd1,
    PIN_ANY    = 2'd2,
    PIN_LOCKED = 2'd3
  } pin_src_e;

endpackage

// File: rtl/plm_gray_counter.sv
module plm_gray_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray
);
  import pll_lock_pkg::*;

  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nx;

  assign bin_nx = bin_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      gray  <= '0;
    end else begin
      bin_q <= bin_nx;
      gray  <= CNT_W'(plm_bin2gray(32'(bin_nx)));
    end
  end
endmodule

// File: rtl/plm_gray_sync.sv
module plm_gray_sync #(
  parameter int CNT_W  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] bin_out
);
  import pll_lock_pkg::*;

  logic [CNT_W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= gray_in;
        else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign bin_out = CNT_W'(plm_gray2bin(32'(stage_q[STAGES-1])));
endmodule

// File: rtl/plm_freq_detector.sv
module plm_freq_detector #(
  parameter int CNT_W        = 12,
  parameter int GATE_W       = 16,
  parameter int NOM_W        = 12,
  parameter int ERR_W        = 10,
  parameter int AVG_MAX_LOG2 = 7,
  parameter int AVG_W        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CNT_W-1:0]  cnt_bin,
  input  logic [GATE_W-1:0] gate_len,
  input  logic [NOM_W-1:0]  nominal_cnt,
  input  logic [AVG_W-1:0]  avg_log2,
  input  logic [ERR_W-1:0]  lock_thr,
  input  logic [ERR_W-1:0]  unlock_thr,
  output logic              freq_unlock,
  output logic              eval,
  output logic [ERR_W-1:0]  err,
  output logic [ERR_W-1:0]  lock_eff,
  output logic [ERR_W-1:0]  unlock_eff
);
  import pll_lock_pkg::*;

  localparam int ACC_W = CNT_W + AVG_MAX_LOG2 + 1;
  localparam int WIN_W = AVG_MAX_LOG2 + 1;

  logic [GATE_W-1:0] gate_cnt_q;
  logic [CNT_W-1:0]  base_q;
  logic [ACC_W-1:0]  acc_q;
  logic [WIN_W-1:0]  win_q;

  logic [AVG_W-1:0]  avg_eff;
  logic              gate_end;
  logic              win_last;
  logic [CNT_W-1:0]  win_count;
  logic [ACC_W-1:0]  acc_sum;
  logic [31:0]       expected;
  logic [WIN_W-1:0]  win_target;

  assign avg_eff    = (32'(avg_log2) > AVG_MAX_LOG2) ? AVG_W'(AVG_MAX_LOG2) : avg_log2;
  assign gate_end   = ({1'b0, gate_cnt_q} + 1'b1) >= {1'b0, gate_len};
  assign win_target = WIN_W'((32'd1 << avg_eff) - 32'd1);
  assign win_last   = (win_q == win_target);
  assign win_count  = cnt_bin - base_q;
  assign acc_sum    = acc_q + ACC_W'(win_count);
  assign expected   = 32'(nominal_cnt) << avg_eff;

  assign err        = ERR_W'(plm_saturate(plm_abs_diff(32'(acc_sum), expected), 32'(ERR_W)));
  assign lock_eff   = ERR_W'(plm_scale_thr(32'(lock_thr), 32'(avg_eff), 32'(ERR_W)));
  assign unlock_eff = ERR_W'(plm_scale_thr(32'(unlock_thr), 32'(avg_eff), 32'(ERR_W)));
  assign eval       = gate_end & win_last & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_cnt_q  <= '0;
      base_q      <= '0;
      acc_q       <= '0;
      win_q       <= '0;
      freq_unlock <= 1'b1;
    end else if (restart) begin
      gate_cnt_q  <= '0;
      base_q      <= cnt_bin;
      acc_q       <= '0;
      win_q       <= '0;
      freq_unlock <= 1'b1;
    end else if (gate_end) begin
      gate_cnt_q <= '0;
      base_q     <= cnt_bin;
      if (win_last) begin
        acc_q       <= '0;
        win_q       <= '0;
        freq_unlock <= plm_hyst(freq_unlock, 32'(err), 32'(lock_eff), 32'(unlock_eff));
      end else begin
        acc_q <= acc_sum;
        win_q <= win_q + 1'b1;
      end
    end else begin
      gate_cnt_q <= gate_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/plm_phase_detector.sv
module plm_phase_detector #(
  parameter int PH_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            valid,
  input  logic [PH_W-1:0] sample,
  input  logic [PH_W-1:0] lock_thr,
  input  logic [PH_W-1:0] unlock_thr,
  output logic            phase_unlock,
  output logic            eval,
  output logic [PH_W-1:0] mag
);
  import pll_lock_pkg::*;

  assign mag  = sample[PH_W-1] ? PH_W'(~sample + 1'b1) : sample;
  assign eval = valid & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_unlock <= 1'b1;
    else if (restart) phase_unlock <= 1'b1;
    else if (valid)
      phase_unlock <= plm_hyst(phase_unlock, 32'(mag), 32'(lock_thr), 32'(unlock_thr));
  end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int CNT_W        = 12,
  parameter int GATE_W       = 16,
  parameter int NOM_W        = 12,
  parameter int ERR_W        = 10,
  parameter int AVG_MAX_LOG2 = 7,
  parameter int PH_W         = 6,
  parameter int NPINS        = 2,
  parameter int SYNC_STAGES  = 2,
  localparam int AVG_W       = $clog2(AVG_MAX_LOG2 + 1)
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               fb_clk,
  input  logic               alt_clk,
  input  logic               alt_mode,
  input  logic               restart,
  input  logic [GATE_W-1:0]  gate_len,
  input  logic [NOM_W-1:0]   nominal_cnt,
  input  logic [AVG_W-1:0]   avg_log2,
  input  logic [ERR_W-1:0]   freq_lock_thr,
  input  logic [ERR_W-1:0]   freq_unlock_thr,
  input  logic               ph_valid,
  input  logic [PH_W-1:0]    ph_err,
  input  logic [PH_W-1:0]    ph_lock_thr,
  input  logic [PH_W-1:0]    ph_unlock_thr,
  input  logic [2*NPINS-1:0] pin_sel,
  output logic [3:0]         status,
  output logic [NPINS-1:0]   pin_out
);
  import pll_lock_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC-1:0]  src_clk;
  logic [CNT_W-1:0] src_gray [NSRC];
  logic [CNT_W-1:0] src_bin  [NSRC];
  logic [CNT_W-1:0] meas_bin;

  logic             alt_q;
  logic             restart_evt;
  logic             freq_unlock;
  logic             phase_unlock;
  logic             all_locked;
  logic             freq_eval;
  logic [ERR_W-1:0] freq_err;
  logic [ERR_W-1:0] freq_lock_eff;
  logic [ERR_W-1:0] freq_unlock_eff;
  logic             ph_eval;
  logic [PH_W-1:0]  ph_mag;

  assign src_clk = {alt_clk, fb_clk};

  // One counter per measurable clock, each brought into the reference domain.
  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      plm_gray_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (src_clk[s]),
        .rst_n (rst_n),
        .gray  (src_gray[s])
      );
      plm_gray_sync #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .gray_in (src_gray[s]),
        .bin_out (src_bin[s])
      );
    end
  endgenerate

  assign meas_bin = alt_mode ? src_bin[1] : src_bin[0];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) alt_q <= 1'b0;
    else        alt_q <= alt_mode;
  end

  assign restart_evt = restart | (alt_mode ^ alt_q);

  plm_freq_detector #(
    .CNT_W(CNT_W), .GATE_W(GATE_W), .NOM_W(NOM_W), .ERR_W(ERR_W),
    .AVG_MAX_LOG2(AVG_MAX_LOG2), .AVG_W(AVG_W)
  ) u_freq (
    .clk         (ref_clk),
    .rst_n       (rst_n),
    .restart     (restart_evt),
    .cnt_bin     (meas_bin),
    .gate_len    (gate_len),
    .nominal_cnt (nominal_cnt),
    .avg_log2    (avg_log2),
    .lock_thr    (freq_lock_thr),
    .unlock_thr  (freq_unlock_thr),
    .freq_unlock (freq_unlock),
    .eval        (freq_eval),
    .err         (freq_err),
    .lock_eff    (freq_lock_eff),
    .unlock_eff  (freq_unlock_eff)
  );

  plm_phase_detector #(.PH_W(PH_W)) u_phase (
    .clk          (ref_clk),
    .rst_n        (rst_n),
    .restart      (restart_evt),
    .valid        (ph_valid),
    .sample       (ph_err),
    .lock_thr     (ph_lock_thr),
    .unlock_thr   (ph_unlock_thr),
    .phase_unlock (phase_unlock),
    .eval         (ph_eval),
    .mag          (ph_mag)
  );

  assign all_locked = ~(freq_unlock | phase_unlock);
  assign status     = {alt_q, all_locked, phase_unlock, freq_unlock};

  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      pin_src_e sel;
      assign sel = pin_src_e'(pin_sel[2*p +: 2]);
      always_comb begin
        case (sel)
          PIN_FREQ:  pin_out[p] = freq_unlock;
          PIN_PHASE: pin_out[p] = phase_unlock;
          PIN_ANY:   pin_out[p] = freq_unlock | phase_unlock;
          default:   pin_out[p] = all_locked;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk #(
  parameter int ERR_W = 10,
  parameter int PH_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart_evt,
  input logic             freq_eval,
  input logic [ERR_W-1:0] freq_err,
  input logic [ERR_W-1:0] freq_lock_eff,
  input logic [ERR_W-1:0] freq_unlock_eff,
  input logic             freq_unlock,
  input logic             ph_eval,
  input logic [PH_W-1:0]  ph_mag,
  input logic [PH_W-1:0]  ph_lock_thr,
  input logic [PH_W-1:0]  ph_unlock_thr,
  input logic             phase_unlock
);
  AST_FREQ_CLEAR_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freq_unlock) |-> $past(freq_eval) && ($past(freq_err) < $past(freq_lock_eff))); // R1
  AST_FREQ_SET_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_unlock) |-> $past(restart_evt) || ($past(freq_err) > $past(freq_unlock_eff))); // R2
  AST_FREQ_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    freq_eval && (freq_err >= freq_lock_eff) && (freq_err <= freq_unlock_eff)
      |=> $stable(freq_unlock)); // R3
  AST_FREQ_GROUP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_eval && !restart_evt |=> $stable(freq_unlock)); // R5
  AST_PHASE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_eval && !restart_evt |=> $stable(phase_unlock)); // R7
  AST_PHASE_CLEAR_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_unlock) |-> $past(ph_mag) < $past(ph_lock_thr)); // R7
  AST_PHASE_SET_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_unlock) |-> $past(restart_evt) || ($past(ph_mag) > $past(ph_unlock_thr))); // R7
  AST_RESTART_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> freq_unlock && phase_unlock); // R9
endmodule

bind pll_lock_monitor pll_lock_monitor_chk #(.ERR_W(ERR_W), .PH_W(PH_W)) u_chk (
  .clk             (ref_clk),
  .rst_n           (rst_n),
  .restart_evt     (restart_evt),
  .freq_eval       (freq_eval),
  .freq_err        (freq_err),
  .freq_lock_eff   (freq_lock_eff),
  .freq_unlock_eff (freq_unlock_eff),
  .freq_unlock     (freq_unlock),
  .ph_eval         (ph_eval),
  .ph_mag          (ph_mag),
  .ph_lock_thr     (ph_lock_thr),
  .ph_unlock_thr   (ph_unlock_thr),
  .phase_unlock    (phase_unlock)
);

// File: tb/pll_lock_monitor_test.sv
`timescale 1ns/1ps
module pll_lock_monitor_test;
  localparam int GATE_W = 16, NOM_W = 12, ERR_W = 10, PH_W = 6, NPINS = 2, AVG_W = 3;

  logic ref_clk = 0, fb_clk = 0, alt_clk = 0, rst_n = 0;
  logic alt_mode = 0, restart = 0, ph_valid = 0;
  logic [GATE_W-1:0] gate_len = 16;
  logic [NOM_W-1:0]  nominal_cnt = 16;
  logic [AVG_W-1:0]  avg_log2 = 2;
  logic [ERR_W-1:0]  freq_lock_thr = 2, freq_unlock_thr = 5;
  logic [PH_W-1:0]   ph_err = 0, ph_lock_thr = 5, ph_unlock_thr = 10;
  logic [2*NPINS-1:0] pin_sel = 0;
  logic [3:0]        status;
  logic [NPINS-1:0]  pin_out;

  real fb_half = 80.0 / 19.0, alt_half = 80.0 / 16.0;
  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  always #5 ref_clk = ~ref_clk;
  always #(fb_half) fb_clk = ~fb_clk;
  always #(alt_half) alt_clk = ~alt_clk;

  pll_lock_monitor uut (
    .ref_clk(ref_clk), .rst_n(rst_n), .fb_clk(fb_clk), .alt_clk(alt_clk),
    .alt_mode(alt_mode), .restart(restart), .gate_len(gate_len),
    .nominal_cnt(nominal_cnt), .avg_log2(avg_log2), .freq_lock_thr(freq_lock_thr),
    .freq_unlock_thr(freq_unlock_thr), .ph_valid(ph_valid), .ph_err(ph_err),
    .ph_lock_thr(ph_lock_thr), .ph_unlock_thr(ph_unlock_thr), .pin_sel(pin_sel),
    .status(status), .pin_out(pin_out)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // counts per 16-cycle (160 ns) window
  task automatic set_fb(int n);  fb_half  = 80.0 / n; endtask
  task automatic set_alt(int n); alt_half = 80.0 / n; endtask

  task automatic cycles(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic groups(int n);
    cycles(n * int'(gate_len) * (1 << avg_log2));
  endtask

  task automatic pulse_restart();
    restart = 1; cycles(1); restart = 0;
  endtask

  task automatic ph_sample(logic [PH_W-1:0] v);
    ph_valid = 1; ph_err = v; cycles(1); ph_valid = 0;
  endtask

  function automatic logic ph_model(logic cur, int v, int lk, int ul);
    int m;
    m = (v < 0) ? -v : v;
    if (m < lk) return 1'b0;
    if (m > ul) return 1'b1;
    return cur;
  endfunction

  initial begin
    cycles(3);
    // R9, R10: reset state
    check("R9 reset flags", status, 4'b0011);
    rst_n = 1;
    cycles(2);
    check("R10 status after reset", status, 4'b0011);

    // Main frequency sequence, A=2, scaled lock 8, unlock 20
    groups(6); check("R3 hold set, +12 err", status[0], 1);
    set_fb(22); groups(6); check("R2 set, +24 err", status[0], 1);
    set_fb(19); groups(6); check("R3 hold set after +24", status[0], 1);
    set_fb(16); groups(6); check("R1 clear at nominal", status[0], 0);
    set_fb(13); groups(6); check("R3 hold clear, -12 err", status[0], 0);
    set_fb(10); groups(6); check("R2 set, -24 err", status[0], 1);
    set_fb(13); groups(6); check("R3 hold set, -12 err", status[0], 1);
    set_fb(16); groups(6); check("R1 clear again", status[0], 0);
    set_fb(19); groups(6); check("R3 hold clear, +12 err", status[0], 0);

    // R4: same relative error across averaging factors
    for (int a = 0; a < 4; a++) begin
      avg_log2 = AVG_W'(a);
      set_fb(16); pulse_restart(); groups(6);
      check($sformatf("R4 A=%0d nominal clears", a), status[0], 0);
      set_fb(22); groups(6);
      check($sformatf("R4 A=%0d +6/window sets", a), status[0], 1);
    end

    // R5: decision delay grows with averaging and gate length
    set_fb(16);
    avg_log2 = 0; pulse_restart(); cycles(60);
    check("R5 A=0 decided within 60 cycles", status[0], 0);
    avg_log2 = 3; pulse_restart(); cycles(60);
    check("R5 A=3 no decision before group end", status[0], 1);
    cycles(300);
    check("R5 A=3 decided after groups", status[0], 0);
    avg_log2 = 0; gate_len = 64; nominal_cnt = 64; pulse_restart(); cycles(40);
    check("R5 long gate delays decision", status[0], 1);
    cycles(200);
    check("R5 long gate decided", status[0], 0);
    gate_len = 16; nominal_cnt = 16;

    // R6: clamp at A=7, limit 1023>>7 = 7 per window
    avg_log2 = 7; freq_lock_thr = 12; freq_unlock_thr = 20;
    pulse_restart(); groups(3);
    check("R6 nominal clears at A=7", status[0], 0);
    set_fb(26); groups(3);
    check("R6 clamped threshold sets", status[0], 1);
    avg_log2 = 2; freq_lock_thr = 2; freq_unlock_thr = 5;

    // R8 / R9: alternate oscillator
    set_fb(22); set_alt(16); pulse_restart(); groups(6);
    ph_sample(0);
    check("R8 main loop fast: freq unlocked", status[0], 1);
    check("R7 phase locked before mode change", status[1], 0);
    set_fb(16); groups(6);
    check("R9 freq locked before mode change", status[0], 0);
    set_fb(22);
    alt_mode = 1; cycles(1);
    check("R9 mode change unlocks both", status[1:0], 2'b11);
    check("R10 alt bit follows mode", status[3], 1);
    ph_sample(0);
    groups(6);
    check("R8 alt clock at nominal clears", status[0], 0);
    check("R8 phase monitoring continues", status[1], 0);
    check("R10 both locked bit", status[2], 1);
    set_alt(22); groups(6);
    check("R8 alt clock off-nominal sets", status[0], 1);
    alt_mode = 0; set_fb(16); cycles(1);
    check("R10 alt bit clears", status[3], 0);
    groups(6); ph_sample(0);
    check("R9 locked before restart pulse", status[1:0], 2'b00);
    pulse_restart();
    check("R9 restart pulse unlocks both", status[1:0], 2'b11);

    // R11: pins, with freq locked and phase unlocked
    groups(6); ph_sample(6'h20);
    for (int s0 = 0; s0 < 4; s0++) begin
      for (int s1 = 0; s1 < 4; s1++) begin
        logic [1:0] e0, e1;
        pin_sel = {2'(s1), 2'(s0)};
        cycles(1);
        e0[0] = (s0 == 0) ? 1'b0 : (s0 == 1) ? 1'b1 : (s0 == 2) ? 1'b1 : 1'b0;
        e1[0] = (s1 == 0) ? 1'b0 : (s1 == 1) ? 1'b1 : (s1 == 2) ? 1'b1 : 1'b0;
        check($sformatf("R11 pin sel %0d/%0d", s0, s1), pin_out, {e1[0], e0[0]});
      end
    end
    ph_sample(0); pin_sel = 4'b1100; cycles(1);
    check("R11 pins both locked / freq", pin_out, 2'b10);

    // R7: exhaustive phase sweep
    for (int t = 0; t < 3; t++) begin
      int lk, ul;
      lk = (t == 0) ? 5 : (t == 1) ? 3 : 12;
      ul = (t == 0) ? 10 : (t == 1) ? 20 : 12;
      ph_lock_thr = PH_W'(lk); ph_unlock_thr = PH_W'(ul);
      for (int st = 0; st < 2; st++) begin
        for (int v = -32; v < 32; v++) begin
          logic e;
          ph_sample(st != 0 ? 6'h20 : 6'h00);
          e = ph_model(st != 0, v, lk, ul);
          ph_sample(PH_W'(v));
          check($sformatf("R7 thr %0d/%0d start %0d v=%0d", lk, ul, st, v), status[1], e);
          ph_err = PH_W'(e ? 0 : 32); cycles(1);
          check($sformatf("R7 idle v=%0d ignored", v), status[1], e);
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule